// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block decides, for the instruction sitting in the execute stage of a five-stage single-issue pipeline, where each of its two ALU operands should come from: the register-file read value latched when the instruction was decoded, the result held one stage ahead in the memory stage, or the result held two stages ahead in the write-back stage. It compares the two source register numbers of the execute-stage instruction against the destination number and write-enable of each older instruction. It then drives a 2-bit select for each operand and returns the chosen 32-bit words in the same cycle.

A third, narrower path serves stores. When a load is in write-back and the instruction directly behind it is a store in the memory stage whose data register is the loaded register, a 1-bit select replaces the store data carried down the pipeline with the freshly loaded word. The whole block is combinational. Stall detection, branch resolution, the register file and the pipeline registers sit outside it.

Top module: `fwd_bypass_unit`

## Requirements
- R1: Each operand select uses the encoding 0 = register-file value, 1 = write-back result, 2 = memory-stage result. The operand data output equals the word named by its select in the same evaluation, with no clock edge in between.
- R2: When the memory-stage write-enable is 1, its destination equals an operand's source number, and that number is nonzero, that operand's select is 2.
- R3: When the write-back write-enable is 1, its destination equals an operand's source number, the number is nonzero, and the memory stage does not also match under R2, that operand's select is 1.
- R4: When both older stages write the same nonzero source register, the select is 2, so the newer result wins.
- R5: A source number of 0 always gives select 0, whatever the older stages hold.
- R6: A stage whose write-enable is 0 never causes a forward, even if its destination field equals the source number.
- R7: With no match from either stage, the select is 0 and the output is the register-file value. Operands A and B are decided independently.
- R8: The store-data select is 1, and the store-data output equals the write-back result, exactly when the write-back write-enable and its from-memory flag are both 1, the memory-stage instruction is a store, the write-back destination equals the store's data register number, and that number is nonzero. Otherwise the select is 0 and the output is the store data carried in the memory stage.
- R9: For the sequence sub r2,r1,r3 / and r12,r2,r5 / or r13,r6,r2 / add r14,r2,r2 / sw r15,100(r2), with each register starting at its index plus 100, the and receives -2 through select 2, the or receives -2 through select 1, and the add and the store need no forward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs_idx | input | 5 | First source register number of the execute-stage instruction |
| ex_rt_idx | input | 5 | Second source register number of the execute-stage instruction |
| ex_rs_data | input | 32 | Register-file value read for the first source |
| ex_rt_data | input | 32 | Register-file value read for the second source |
| mem_dst_idx | input | 5 | Destination register number in the memory stage |
| mem_wr_en | input | 1 | Memory-stage instruction writes a register |
| mem_alu_res | input | 32 | ALU result held in the memory stage |
| mem_is_store | input | 1 | Memory-stage instruction is a store |
| mem_st_rt_idx | input | 5 | Data register number of the store in the memory stage |
| mem_st_data | input | 32 | Store data carried in the memory stage |
| wb_dst_idx | input | 5 | Destination register number in the write-back stage |
| wb_wr_en | input | 1 | Write-back instruction writes a register |
| wb_from_mem | input | 1 | Write-back value comes from a load |
| wb_result | input | 32 | Result being written back |
| op_a_sel | output | 2 | Select for operand A |
| op_b_sel | output | 2 | Select for operand B |
| op_a_val | output | 32 | Chosen operand A word |
| op_b_val | output | 32 | Chosen operand B word |
| st_sel | output | 1 | Store-data select (1 = loaded value) |
| st_val | output | 32 | Chosen store-data word |

## Verification
The replayed five-instruction sequence separates a one-ahead forward, a two-ahead forward and the read that the register file already covers. Directed cases then put both stages on the same register to tell the priority apart, place a matching destination under a cleared write-enable or on register zero to show that neither forwards, and vary the load flag, store flag and register numbers of the store path one at a time. Random register numbers drawn from a small range make partial matches frequent, so each operand is seen matching one stage, both, or neither, independently of the other operand.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int IDX_W  = 5;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    FW_RF  = 2'd0,
    FW_WB  = 2'd1,
    FW_MEM = 2'd2
  } fwd_sel_e;
endpackage

// File: rtl/fwd_src_match.sv
module fwd_src_match
  import fwd_pkg::*;
#(
  parameter int IW = IDX_W
) (
  input  logic [IW-1:0] src_idx,
  input  logic [IW-1:0] mem_dst_idx,
  input  logic          mem_wr_en,
  input  logic [IW-1:0] wb_dst_idx,
  input  logic          wb_wr_en,
  output fwd_sel_e      sel
);
  logic src_live;
  logic mem_hit;
  logic wb_hit;

  always_comb begin
    src_live = (src_idx != '0);
    mem_hit  = mem_wr_en && (mem_dst_idx == src_idx) && src_live;
    wb_hit   = wb_wr_en  && (wb_dst_idx  == src_idx) && src_live;
    if (mem_hit)     sel = FW_MEM;
    else if (wb_hit) sel = FW_WB;
    else             sel = FW_RF;
  end

  always_comb begin
    if (src_idx == '0)
      AST_ZERO_NO_FWD: assert (sel == FW_RF) else $error("register zero forwarded"); // R5
    if (!mem_wr_en && !wb_wr_en)
      AST_IDLE_NO_FWD: assert (sel == FW_RF) else $error("forward with no writer"); // R6
    if (mem_wr_en && wb_wr_en && mem_dst_idx == wb_dst_idx && mem_dst_idx == src_idx && src_idx != '0)
      AST_NEWEST_WINS: assert (sel == FW_MEM) else $error("older result won"); // R4
  end
endmodule

// File: rtl/fwd_operand_mux.sv
module fwd_operand_mux
  import fwd_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  fwd_sel_e        sel,
  input  logic [DW-1:0]   rf_data,
  input  logic [DW-1:0]   wb_data,
  input  logic [DW-1:0]   mem_data,
  output logic [DW-1:0]   out_data
);
  localparam int NSRC = 3;
  logic [DW-1:0] cand [NSRC];

  always_comb begin
    cand[0] = rf_data;
    cand[1] = wb_data;
    cand[2] = mem_data;
    if (int'(sel) < NSRC) out_data = cand[int'(sel)];
    else                  out_data = rf_data;
  end

  always_comb begin
    if (sel == FW_MEM)
      AST_MUX_MEM_PICK: assert (out_data == mem_data) else $error("mem pick wrong"); // R1
    if (sel == FW_WB)
      AST_MUX_WB_PICK: assert (out_data == wb_data) else $error("wb pick wrong"); // R1
  end
endmodule

// File: rtl/fwd_store_path.sv
module fwd_store_path
  import fwd_pkg::*;
#(
  parameter int IW = IDX_W,
  parameter int DW = DATA_W
) (
  input  logic [IW-1:0] st_rt_idx,
  input  logic          is_store,
  input  logic [DW-1:0] st_data,
  input  logic [IW-1:0] wb_dst_idx,
  input  logic          wb_wr_en,
  input  logic          wb_from_mem,
  input  logic [DW-1:0] wb_result,
  output logic          sel,
  output logic [DW-1:0] out_data
);
  always_comb begin
    sel = wb_wr_en && wb_from_mem && is_store &&
          (wb_dst_idx == st_rt_idx) && (wb_dst_idx != '0);
    out_data = sel ? wb_result : st_data;
  end

  always_comb begin
    if (sel)
      AST_STORE_NEEDS_LOAD: assert (wb_from_mem && is_store) else $error("store bypass without load"); // R8
    if (!sel)
      AST_STORE_KEEPS_DATA: assert (out_data == st_data) else $error("store data replaced"); // R8
  end
endmodule

// File: rtl/fwd_bypass_unit.sv
module fwd_bypass_unit
  import fwd_pkg::*;
#(
  parameter int IW = IDX_W,
  parameter int DW = DATA_W
) (
  input  logic [IW-1:0] ex_rs_idx,
  input  logic [IW-1:0] ex_rt_idx,
  input  logic [DW-1:0] ex_rs_data,
  input  logic [DW-1:0] ex_rt_data,
  input  logic [IW-1:0] mem_dst_idx,
  input  logic          mem_wr_en,
  input  logic [DW-1:0] mem_alu_res,
  input  logic          mem_is_store,
  input  logic [IW-1:0] mem_st_rt_idx,
  input  logic [DW-1:0] mem_st_data,
  input  logic [IW-1:0] wb_dst_idx,
  input  logic          wb_wr_en,
  input  logic          wb_from_mem,
  input  logic [DW-1:0] wb_result,
  output logic [1:0]    op_a_sel,
  output logic [1:0]    op_b_sel,
  output logic [DW-1:0] op_a_val,
  output logic [DW-1:0] op_b_val,
  output logic          st_sel,
  output logic [DW-1:0] st_val
);
  localparam int NOPS = 2;

  logic [IW-1:0] src_idx [NOPS];
  logic [DW-1:0] rf_data [NOPS];
  logic [DW-1:0] fwd_val [NOPS];
  fwd_sel_e      sel     [NOPS];

  assign src_idx[0] = ex_rs_idx;
  assign src_idx[1] = ex_rt_idx;
  assign rf_data[0] = ex_rs_data;
  assign rf_data[1] = ex_rt_data;

  for (genvar g = 0; g < NOPS; g++) begin : g_opnd
    fwd_src_match #(.IW(IW)) u_match (
      .src_idx     (src_idx[g]),
      .mem_dst_idx (mem_dst_idx),
      .mem_wr_en   (mem_wr_en),
      .wb_dst_idx  (wb_dst_idx),
      .wb_wr_en    (wb_wr_en),
      .sel         (sel[g])
    );
    fwd_operand_mux #(.DW(DW)) u_mux (
      .sel      (sel[g]),
      .rf_data  (rf_data[g]),
      .wb_data  (wb_result),
      .mem_data (mem_alu_res),
      .out_data (fwd_val[g])
    );
  end

  fwd_store_path #(.IW(IW), .DW(DW)) u_store (
    .st_rt_idx   (mem_st_rt_idx),
    .is_store    (mem_is_store),
    .st_data     (mem_st_data),
    .wb_dst_idx  (wb_dst_idx),
    .wb_wr_en    (wb_wr_en),
    .wb_from_mem (wb_from_mem),
    .wb_result   (wb_result),
    .sel         (st_sel),
    .out_data    (st_val)
  );

  assign op_a_sel = sel[0];
  assign op_b_sel = sel[1];
  assign op_a_val = fwd_val[0];
  assign op_b_val = fwd_val[1];

  always_comb begin
    AST_SEL_IN_RANGE: assert (op_a_sel != 2'd3 && op_b_sel != 2'd3) else $error("select out of range"); // R1
  end
endmodule

// File: tb/fwd_bypass_unit_tb.sv
`timescale 1ns/1ps
module fwd_bypass_unit_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [4:0]  ex_rs_idx, ex_rt_idx, mem_dst_idx, mem_st_rt_idx, wb_dst_idx;
  logic [31:0] ex_rs_data, ex_rt_data, mem_alu_res, mem_st_data, wb_result;
  logic        mem_wr_en, mem_is_store, wb_wr_en, wb_from_mem;
  logic [1:0]  op_a_sel, op_b_sel;
  logic [31:0] op_a_val, op_b_val, st_val;
  logic        st_sel;

  int checks = 0;
  int fails  = 0;

  fwd_bypass_unit u_dut (
    .ex_rs_idx(ex_rs_idx), .ex_rt_idx(ex_rt_idx),
    .ex_rs_data(ex_rs_data), .ex_rt_data(ex_rt_data),
    .mem_dst_idx(mem_dst_idx), .mem_wr_en(mem_wr_en), .mem_alu_res(mem_alu_res),
    .mem_is_store(mem_is_store), .mem_st_rt_idx(mem_st_rt_idx), .mem_st_data(mem_st_data),
    .wb_dst_idx(wb_dst_idx), .wb_wr_en(wb_wr_en), .wb_from_mem(wb_from_mem),
    .wb_result(wb_result),
    .op_a_sel(op_a_sel), .op_b_sel(op_b_sel), .op_a_val(op_a_val), .op_b_val(op_b_val),
    .st_sel(st_sel), .st_val(st_val)
  );

  function automatic logic [1:0] exp_sel(logic [4:0] src, logic [4:0] md, logic mwe,
                                         logic [4:0] wd, logic wwe);
    if (src == 5'd0) return 2'd0;                  // R5
    if (mwe && md == src) return 2'd2;              // R2, R4
    if (wwe && wd == src) return 2'd1;              // R3
    return 2'd0;                                    // R7
  endfunction

  function automatic logic [31:0] exp_val(logic [1:0] s, logic [31:0] rf,
                                          logic [31:0] wbv, logic [31:0] memv);
    return (s == 2'd2) ? memv : (s == 2'd1) ? wbv : rf;  // R1
  endfunction

  function automatic logic exp_st(logic wwe, logic wfm, logic st, logic [4:0] wd, logic [4:0] rt);
    return wwe && wfm && st && wd == rt && wd != 5'd0;  // R8
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive_idle();
    ex_rs_idx = 0; ex_rt_idx = 0; ex_rs_data = 0; ex_rt_data = 0;
    mem_dst_idx = 0; mem_wr_en = 0; mem_alu_res = 0; mem_is_store = 0;
    mem_st_rt_idx = 0; mem_st_data = 0;
    wb_dst_idx = 0; wb_wr_en = 0; wb_from_mem = 0; wb_result = 0;
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic check_all(string tag);
    logic [1:0] ea, eb;
    logic       es;
    ea = exp_sel(ex_rs_idx, mem_dst_idx, mem_wr_en, wb_dst_idx, wb_wr_en);
    eb = exp_sel(ex_rt_idx, mem_dst_idx, mem_wr_en, wb_dst_idx, wb_wr_en);
    es = exp_st(wb_wr_en, wb_from_mem, mem_is_store, wb_dst_idx, mem_st_rt_idx);
    chk({tag, " opA sel"}, 32'(op_a_sel), 32'(ea));
    chk({tag, " opB sel"}, 32'(op_b_sel), 32'(eb));
    chk({tag, " opA val"}, op_a_val, exp_val(ea, ex_rs_data, wb_result, mem_alu_res));
    chk({tag, " opB val"}, op_b_val, exp_val(eb, ex_rt_data, wb_result, mem_alu_res));
    chk({tag, " st sel"}, 32'(st_sel), 32'(es));
    chk({tag, " st val"}, st_val, es ? wb_result : mem_st_data);
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    drive_idle();
    repeat (3) @(posedge clk);
    rst = 1'b0;
    settle();
    chk("R7 idle opA sel", 32'(op_a_sel), 32'd0);
    chk("R7 idle opB sel", 32'(op_b_sel), 32'd0);
    chk("R8 idle st sel", 32'(st_sel), 32'd0);

    // R9 replay: cycle with and in EX, sub in MEM
    drive_idle();
    ex_rs_idx = 2; ex_rt_idx = 5; ex_rs_data = 102; ex_rt_data = 105;
    mem_dst_idx = 2; mem_wr_en = 1; mem_alu_res = 32'hFFFF_FFFE;
    settle();
    chk("R9 R2 and opA sel", 32'(op_a_sel), 32'd2);
    chk("R9 R2 and opA val", op_a_val, 32'hFFFF_FFFE);
    chk("R9 and opB val", op_b_val, 32'd105);
    // or in EX, and in MEM, sub in WB
    ex_rs_idx = 6; ex_rt_idx = 2; ex_rs_data = 106; ex_rt_data = 102;
    mem_dst_idx = 12; mem_alu_res = 32'd104;
    wb_dst_idx = 2; wb_wr_en = 1; wb_result = 32'hFFFF_FFFE;
    settle();
    chk("R9 R3 or opB sel", 32'(op_b_sel), 32'd1);
    chk("R9 R3 or opB val", op_b_val, 32'hFFFF_FFFE);
    chk("R9 or opA sel", 32'(op_a_sel), 32'd0);
    // add in EX, or in MEM, and in WB; register file already has -2
    ex_rs_idx = 2; ex_rt_idx = 2; ex_rs_data = 32'hFFFF_FFFE; ex_rt_data = 32'hFFFF_FFFE;
    mem_dst_idx = 13; mem_alu_res = 32'hFFFF_FFFE;
    wb_dst_idx = 12; wb_result = 32'd104;
    settle();
    chk("R9 R7 add opA sel", 32'(op_a_sel), 32'd0);
    chk("R9 R7 add opB sel", 32'(op_b_sel), 32'd0);
    chk("R9 add opA val", op_a_val, 32'hFFFF_FFFE);
    // sw in EX, add in MEM, or in WB
    ex_rs_idx = 2; ex_rt_idx = 15; ex_rt_data = 115;
    mem_dst_idx = 14; mem_alu_res = 32'hFFFF_FFFC;
    wb_dst_idx = 13; wb_result = 32'hFFFF_FFFE;
    settle();
    chk("R9 sw opA sel", 32'(op_a_sel), 32'd0);
    chk("R9 sw opB sel", 32'(op_b_sel), 32'd0);

    // R4: both stages write r7
    drive_idle();
    ex_rs_idx = 7; ex_rt_idx = 7; ex_rs_data = 1; ex_rt_data = 1;
    mem_dst_idx = 7; mem_wr_en = 1; mem_alu_res = 32'hAAAA_0001;
    wb_dst_idx = 7; wb_wr_en = 1; wb_result = 32'hBBBB_0002;
    settle();
    chk("R4 newest opA sel", 32'(op_a_sel), 32'd2);
    chk("R4 newest opB val", op_b_val, 32'hAAAA_0001);
    // R6: memory stage not writing, stale match -> write-back wins
    mem_wr_en = 0;
    settle();
    chk("R6 R3 stale mem opA sel", 32'(op_a_sel), 32'd1);
    chk("R6 stale mem opA val", op_a_val, 32'hBBBB_0002);
    wb_wr_en = 0;
    settle();
    chk("R6 no writer opA sel", 32'(op_a_sel), 32'd0);
    chk("R6 no writer opA val", op_a_val, 32'd1);
    // R5: register zero
    ex_rs_idx = 0; ex_rt_idx = 0; mem_dst_idx = 0; wb_dst_idx = 0;
    mem_wr_en = 1; wb_wr_en = 1;
    settle();
    chk("R5 zero opA sel", 32'(op_a_sel), 32'd0);
    chk("R5 zero opB val", op_b_val, 32'd1);

    // R8 store path
    drive_idle();
    mem_is_store = 1; mem_st_rt_idx = 9; mem_st_data = 32'h1111_1111;
    wb_dst_idx = 9; wb_wr_en = 1; wb_from_mem = 1; wb_result = 32'h2222_2222;
    settle();
    chk("R8 load-store sel", 32'(st_sel), 32'd1);
    chk("R8 load-store val", st_val, 32'h2222_2222);
    wb_from_mem = 0;
    settle();
    chk("R8 not load sel", 32'(st_sel), 32'd0);
    chk("R8 not load val", st_val, 32'h1111_1111);
    wb_from_mem = 1; mem_is_store = 0;
    settle();
    chk("R8 not store sel", 32'(st_sel), 32'd0);
    mem_is_store = 1; wb_wr_en = 0;
    settle();
    chk("R8 R6 no write sel", 32'(st_sel), 32'd0);
    wb_wr_en = 1; wb_dst_idx = 0; mem_st_rt_idx = 0;
    settle();
    chk("R8 R5 zero sel", 32'(st_sel), 32'd0);
    chk("R8 zero val", st_val, 32'h1111_1111);

    // Random mix, small register range for frequent matches
    for (int i = 0; i < 400; i++) begin
      ex_rs_idx = 5'($urandom_range(0, 3));
      ex_rt_idx = 5'($urandom_range(0, 3));
      mem_dst_idx = 5'($urandom_range(0, 3));
      wb_dst_idx = 5'($urandom_range(0, 3));
      mem_st_rt_idx = 5'($urandom_range(0, 3));
      mem_wr_en = 1'($urandom);
      wb_wr_en = 1'($urandom);
      wb_from_mem = 1'($urandom);
      mem_is_store = 1'($urandom);
      ex_rs_data = $urandom; ex_rt_data = $urandom;
      mem_alu_res = $urandom; mem_st_data = $urandom; wb_result = $urandom;
      settle();
      check_all("R1 R2 R3 R4 R5 R6 R7 R8 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule